// File: doc/BRIEF.md
# Interrupt Entry Micro-Operation Sequencer

This block is the register-transfer controller of a small accumulator-style CPU datapath. It owns the program counter, the memory address register and the memory buffer register, plus an instruction register that receives each fetched word. While no interrupt is waiting, it repeats a three-step fetch. First the address register takes the program counter. Next the buffer register captures the memory word and the program counter advances. Last the instruction register takes the buffer contents.

An interrupt request is latched as pending. It is acted on only when a fetch completes, which is the instruction boundary. At that point the block runs a fixed three-step entry sequence. The first step copies the current program counter into the buffer register and pulses the acknowledge. The second step points the address register at the fixed save location and, in the same step, loads the program counter with the fixed service-routine start. The third step writes the buffer register to memory. Fetching then resumes at the service routine. The address register alone drives the memory address, and the buffer register alone drives the write data.

Top module: `irq_entry_seq`

## Requirements
- R1: While rst_n is low, and in the cycle after it rises, pc_out equals RESET_PC, ir_out is 0, mem_addr and mem_wdata are 0, and mem_we and irq_ack are 0.
- R2: A fetch takes three cycles. In the first cycle the address register loads the program counter. In the second cycle mem_addr shows that address and mem_rdata is captured into the buffer register. In the third cycle ir_out takes the captured word one edge later. mem_rdata is read in the same cycle the address is shown.
- R3: A request on irq_req is acted on only after the fetch in progress finishes. irq_ack never rises in the middle of a fetch.
- R4: irq_ack is high for exactly one cycle, the first cycle of the entry sequence, and mem_we is low in that cycle.
- R5: In the entry sequence, the cycle after irq_ack shows the program counter value from the acknowledge cycle on mem_wdata.
- R6: In the second entry step, the program counter loads ISR_ADDR and the address register loads SAVE_ADDR on the same edge.
- R7: Two cycles after irq_ack, mem_we is high for exactly one cycle, with mem_addr equal to SAVE_ADDR and mem_wdata equal to the saved return address.
- R8: After the write step, fetching resumes at ISR_ADDR.
- R9: A request raised while the entry sequence runs, including in its acknowledge cycle, stays pending. It starts a new entry after the next complete fetch.
- R10: With no request pending, mem_we and irq_ack stay low.
- R11: The program counter increments modulo 2^WORD_W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_req | input | 1 | Interrupt request, sampled every cycle into a pending latch |
| irq_ack | output | 1 | One-cycle acknowledge at the start of entry |
| mem_addr | output | WORD_W | Memory address, driven by the address register |
| mem_wdata | output | WORD_W | Memory write data, driven by the buffer register |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | WORD_W | Memory read data, valid in the cycle its address is shown |
| pc_out | output | WORD_W | Current program counter |
| ir_out | output | WORD_W | Instruction register |

## Verification
The bench builds the block with an 8-bit word, RESET_PC = 0xFE, SAVE_ADDR = 0x40 and ISR_ADDR = 0x80. The narrow word lets the program counter wrap from 0xFF to 0x00 within the second fetch. That wrap happens just before an entry, so the saved return address is the wrapped value. The save and service addresses are distinct from any fetch address reached in the run, so a write or a jump to the wrong place shows up on the memory port. The bench memory returns the inverted address, which ties each fetched word to the address it came from.

// File: rtl/irq_seq_pkg.sv
// Package: shared state encoding and micro-operation strobes for the
// interrupt entry sequencer. Assumes a single-issue, one-step-per-cycle flow.
package irq_seq_pkg;

    typedef enum logic [2:0] {
        ST_FETCH_ADDR  = 3'd0,  // address register <- program counter
        ST_FETCH_READ  = 3'd1,  // buffer <- memory, program counter + 1
        ST_FETCH_LOAD  = 3'd2,  // instruction register <- buffer (boundary)
        ST_ENTRY_SAVE  = 3'd3,  // buffer <- program counter, acknowledge
        ST_ENTRY_AIM   = 3'd4,  // address <- save slot, pc <- service start
        ST_ENTRY_WRITE = 3'd5   // memory[address] <- buffer
    } seq_state_e;

    typedef struct packed {
        logic mar_from_pc;
        logic mar_from_save;
        logic mbr_from_mem;
        logic mbr_from_pc;
        logic pc_step;
        logic pc_from_isr;
        logic ir_from_mbr;
        logic mem_write;
        logic ack;
    } uop_t;

endpackage

// File: rtl/irq_pending.sv
// Module: holds an interrupt request until the sequencer takes it.
// Assumes irq_req is an event: any cycle it is high sets the latch, and a
// request in the same cycle as the take keeps the latch set.
module irq_pending (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_req,
    input  logic take,
    output logic pending
);

    // Set on any request, clear when taken unless a new request arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else begin
            pending <= (pending & ~take) | irq_req;
        end
    end

endmodule

// File: rtl/seq_ctrl.sv
// Module: step sequencer. It walks the three fetch steps and, at the
// boundary, branches into the three entry steps when a request is pending.
// Assumes one micro-operation step per clock.
module seq_ctrl
    import irq_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    output logic take,
    output uop_t uop
);

    seq_state_e state_q;
    seq_state_e state_d;

    // Next-step selection; the only branch point is the end of a fetch.
    always_comb begin
        case (state_q)
            ST_FETCH_ADDR:  state_d = ST_FETCH_READ;
            ST_FETCH_READ:  state_d = ST_FETCH_LOAD;
            ST_FETCH_LOAD:  state_d = pending ? ST_ENTRY_SAVE : ST_FETCH_ADDR;
            ST_ENTRY_SAVE:  state_d = ST_ENTRY_AIM;
            ST_ENTRY_AIM:   state_d = ST_ENTRY_WRITE;
            ST_ENTRY_WRITE: state_d = ST_FETCH_ADDR;
            default:        state_d = ST_FETCH_ADDR;
        endcase
    end

    // Step register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FETCH_ADDR;
        end else begin
            state_q <= state_d;
        end
    end

    // Decode the current step into transfer strobes.
    always_comb begin
        uop = '0;
        case (state_q)
            ST_FETCH_ADDR:  uop.mar_from_pc = 1'b1;
            ST_FETCH_READ: begin
                uop.mbr_from_mem = 1'b1;
                uop.pc_step      = 1'b1;
            end
            ST_FETCH_LOAD:  uop.ir_from_mbr = 1'b1;
            ST_ENTRY_SAVE: begin
                uop.mbr_from_pc = 1'b1;
                uop.ack         = 1'b1;
            end
            ST_ENTRY_AIM: begin
                uop.mar_from_save = 1'b1;
                uop.pc_from_isr   = 1'b1;
            end
            ST_ENTRY_WRITE: uop.mem_write = 1'b1;
            default:        uop = '0;
        endcase
    end

    assign take = uop.ack;

endmodule

// File: rtl/seq_datapath.sv
// Module: program counter, address, buffer and instruction registers.
// Each register loads from the source named by the active strobe; the
// strobes from the sequencer never select two sources for one register.
module seq_datapath
    import irq_seq_pkg::*;
#(
    parameter int unsigned             WORD_W    = 16,
    parameter logic [WORD_W-1:0]       RESET_PC  = '0,
    parameter logic [WORD_W-1:0]       SAVE_ADDR = '0,
    parameter logic [WORD_W-1:0]       ISR_ADDR  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  uop_t              uop,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [WORD_W-1:0] pc_q,
    output logic [WORD_W-1:0] mar_q,
    output logic [WORD_W-1:0] mbr_q,
    output logic [WORD_W-1:0] ir_q
);

    localparam logic [WORD_W-1:0] PC_ONE = WORD_W'(1);

    // Program counter: step after a read, jump at entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= RESET_PC;
        end else if (uop.pc_from_isr) begin
            pc_q <= ISR_ADDR;
        end else if (uop.pc_step) begin
            pc_q <= pc_q + PC_ONE;
        end
    end

    // Address register: sole source of the memory address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mar_q <= '0;
        end else if (uop.mar_from_save) begin
            mar_q <= SAVE_ADDR;
        end else if (uop.mar_from_pc) begin
            mar_q <= pc_q;
        end
    end

    // Buffer register: captures read data or the return address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mbr_q <= '0;
        end else if (uop.mbr_from_pc) begin
            mbr_q <= pc_q;
        end else if (uop.mbr_from_mem) begin
            mbr_q <= mem_rdata;
        end
    end

    // Instruction register: takes the fetched word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q <= '0;
        end else if (uop.ir_from_mbr) begin
            ir_q <= mbr_q;
        end
    end

endmodule

// File: rtl/irq_entry_seq.sv
// Module: top of the interrupt entry sequencer. Connects the pending
// latch, the step sequencer and the register datapath to the memory port.
// Assumes mem_rdata is valid in the same cycle as mem_addr.
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter int unsigned             WORD_W    = 16,
    parameter logic [WORD_W-1:0]       RESET_PC  = 16'h0200,
    parameter logic [WORD_W-1:0]       SAVE_ADDR = 16'h0010,
    parameter logic [WORD_W-1:0]       ISR_ADDR  = 16'h0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_req,
    output logic              irq_ack,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [WORD_W-1:0] pc_out,
    output logic [WORD_W-1:0] ir_out
);

    logic              pending;
    logic              take;
    uop_t              uop;
    logic [WORD_W-1:0] pc_q;
    logic [WORD_W-1:0] mar_q;
    logic [WORD_W-1:0] mbr_q;
    logic [WORD_W-1:0] ir_q;

    irq_pending u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_req (irq_req),
        .take    (take),
        .pending (pending)
    );

    seq_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (pending),
        .take    (take),
        .uop     (uop)
    );

    seq_datapath #(
        .WORD_W    (WORD_W),
        .RESET_PC  (RESET_PC),
        .SAVE_ADDR (SAVE_ADDR),
        .ISR_ADDR  (ISR_ADDR)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .uop       (uop),
        .mem_rdata (mem_rdata),
        .pc_q      (pc_q),
        .mar_q     (mar_q),
        .mbr_q     (mbr_q),
        .ir_q      (ir_q)
    );

    assign mem_addr  = mar_q;
    assign mem_wdata = mbr_q;
    assign mem_we    = uop.mem_write;
    assign irq_ack   = uop.ack;
    assign pc_out    = pc_q;
    assign ir_out    = ir_q;

endmodule

// File: rtl/irq_seq_chk.sv
// Module: property checker for the entry sequence, observing ports only.
module irq_seq_chk #(
    parameter int unsigned       WORD_W    = 16,
    parameter logic [WORD_W-1:0] SAVE_ADDR = '0,
    parameter logic [WORD_W-1:0] ISR_ADDR  = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_ack,
    input logic              mem_we,
    input logic [WORD_W-1:0] mem_addr,
    input logic [WORD_W-1:0] mem_wdata,
    input logic [WORD_W-1:0] pc_out
);

    a_r4_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !irq_ack);

    a_r4_no_write_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> !mem_we);

    a_r5_return_in_buffer: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> (mem_wdata == $past(pc_out)));

    a_r7_write_follows_ack: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> ##1 mem_we);

    a_r7_write_at_slot: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr == SAVE_ADDR));

    a_r6_pc_at_service: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (pc_out == ISR_ADDR));

    a_r7_write_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

endmodule

bind irq_entry_seq irq_seq_chk #(
    .WORD_W    (WORD_W),
    .SAVE_ADDR (SAVE_ADDR),
    .ISR_ADDR  (ISR_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_ack   (irq_ack),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .pc_out    (pc_out)
);

// File: tb/tb_irq_entry_seq.sv
// Bench: per-cycle vector table, then directed reset and idle-run tests.
module tb_irq_entry_seq;

    localparam int unsigned W    = 8;
    localparam logic [W-1:0] RPC = 8'hFE;
    localparam logic [W-1:0] SAV = 8'h40;
    localparam logic [W-1:0] ISR = 8'h80;
    localparam int NVEC = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         irq_req = 1'b0;
    logic         irq_ack;
    logic [W-1:0] mem_addr;
    logic [W-1:0] mem_wdata;
    logic         mem_we;
    logic [W-1:0] mem_rdata;
    logic [W-1:0] pc_out;
    logic [W-1:0] ir_out;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    always #10 clk = ~clk;  // 50 MHz

    assign mem_rdata = ~mem_addr;  // memory model: word = inverted address

    irq_entry_seq #(
        .WORD_W(W), .RESET_PC(RPC), .SAVE_ADDR(SAV), .ISR_ADDR(ISR)
    ) dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_ack(irq_ack),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_rdata(mem_rdata), .pc_out(pc_out), .ir_out(ir_out)
    );

    // fields: irq(drive after sampling), ack, we, addr, wdata, pc, ir
    localparam logic [34:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'hFE, 8'h00},  // 0  fetch addr
        {1'b0, 1'b0, 1'b0, 8'hFE, 8'h00, 8'hFE, 8'h00},  // 1  fetch read R2
        {1'b0, 1'b0, 1'b0, 8'hFE, 8'h01, 8'hFF, 8'h00},  // 2  fetch load
        {1'b1, 1'b0, 1'b0, 8'hFE, 8'h01, 8'hFF, 8'h01},  // 3  request mid-fetch R3
        {1'b0, 1'b0, 1'b0, 8'hFF, 8'h01, 8'hFF, 8'h01},  // 4  no ack yet R3
        {1'b0, 1'b0, 1'b0, 8'hFF, 8'h00, 8'h00, 8'h01},  // 5  pc wrapped R11
        {1'b0, 1'b1, 1'b0, 8'hFF, 8'h00, 8'h00, 8'h00},  // 6  ack R4
        {1'b0, 1'b0, 1'b0, 8'hFF, 8'h00, 8'h00, 8'h00},  // 7  buffer=pc R5
        {1'b1, 1'b0, 1'b1, 8'h40, 8'h00, 8'h80, 8'h00},  // 8  write R6 R7, new req R9
        {1'b0, 1'b0, 1'b0, 8'h40, 8'h00, 8'h80, 8'h00},  // 9  back to fetch R8
        {1'b0, 1'b0, 1'b0, 8'h80, 8'h00, 8'h80, 8'h00},  // 10 fetch at service R8
        {1'b0, 1'b0, 1'b0, 8'h80, 8'h7F, 8'h81, 8'h00},  // 11
        {1'b0, 1'b1, 1'b0, 8'h80, 8'h7F, 8'h81, 8'h7F},  // 12 pending taken R9
        {1'b0, 1'b0, 1'b0, 8'h80, 8'h81, 8'h81, 8'h7F},  // 13
        {1'b0, 1'b0, 1'b1, 8'h40, 8'h81, 8'h80, 8'h7F},  // 14 second write R7
        {1'b0, 1'b0, 1'b0, 8'h40, 8'h81, 8'h80, 8'h7F}   // 15 nothing pending R10
    };

    task automatic check(input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        irq_req = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            fails++;
            tests++;
            $display("FAIL watchdog: got %0d cycles expected <= 5000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state, observed while reset is held
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 pc", pc_out, RPC);
        check("R1 ir", ir_out, '0);
        check("R1 we", {7'd0, mem_we}, '0);
        check("R1 ack", {7'd0, irq_ack}, '0);

        apply_reset();
        for (int k = 0; k < NVEC; k++) begin
            check("R4 ack",   {7'd0, irq_ack}, {7'd0, VEC[k][33]});
            check("R7 we",    {7'd0, mem_we},  {7'd0, VEC[k][32]});
            check("R2 addr",  mem_addr,  VEC[k][31:24]);
            check("R5 wdata", mem_wdata, VEC[k][23:16]);
            check("R6 pc",    pc_out,    VEC[k][15:8]);
            check("R2 ir",    ir_out,    VEC[k][7:0]);
            irq_req = VEC[k][34];
            @(negedge clk);
        end
        irq_req = 1'b0;

        // R1: reset in mid-entry returns to reset state
        irq_req = 1'b1;
        repeat (4) @(negedge clk);
        irq_req = 1'b0;
        apply_reset();
        check("R1 pc after reset", pc_out, RPC);
        check("R1 addr after reset", mem_addr, '0);
        check("R1 wdata after reset", mem_wdata, '0);

        // R10: idle run, no write and no ack; pc steps once per fetch
        begin
            int seen = 0;
            for (int c = 0; c < 30; c++) begin
                if (mem_we || irq_ack) seen++;
                @(negedge clk);
            end
            check("R10 strobes", seen[W-1:0], '0);
            check("R11 pc after 10 fetches", pc_out, 8'h08);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule